// File: doc/BRIEF.md
# DAC Output Load and Clear Arbiter

This block sits between the per-channel holding registers of a multi-channel DAC and its output registers. It decides in which clock cycle the active holding value of each channel is copied into the output register. Three things can hold a copy back: an internal calculation that is still running, an A/B-select write, or another device on a shared open-drain busy line. The block drives that line low while its own work is pending. It also samples the line, so a load waits until every device on the line has released it.

A falling edge on the active-low load strobe asks for an update. If the sampled busy line is low when the edge arrives, the request is stored and fires in the cycle after the line returns high. If the strobe is held low, an update fires each time the line rises. While the active-low clear input is low, the block reports the cleared state and ignores every load strobe; clearing does not touch any register contents. The block keeps a written-since-last-load flag for each channel, and a load enables only the channels whose flag is set.

The sequencer has three states. In `ST_IDLE` it waits for a request. `ST_IDLE -> ST_FIRE` is taken when a request arrives with the line high. `ST_IDLE -> ST_PEND` is taken when a request arrives with the line low. `ST_PEND -> ST_FIRE` is taken when the line goes high. `ST_PEND -> ST_IDLE` discards the request when clear goes low. `ST_FIRE -> ST_IDLE` is taken after the load enables have been issued, or when clear is low. `ST_FIRE -> ST_PEND` is taken if the line fell again before the enables could be issued.

Top module: `dac_update_arbiter`

## Requirements
- R1: `busy_oe` is 1 (pull the shared line low) in every cycle in which `calc_busy` is 1 or the A/B-select hold timer is running.
- R2: A one-cycle pulse on `absel_wr` holds `busy_oe` at 1 for exactly ABSEL_CYC consecutive cycles, starting in the cycle after the pulse.
- R3: No bit of `ld_en` is 1 in a cycle in which `busy_line` is low.
- R4: A falling edge of `load_n` sampled while `busy_line` is high and `clr_n` is high raises `ld_en` in the next cycle, for one cycle.
- R5: A falling edge of `load_n` sampled while `busy_line` is low is stored. `ld_en` rises in the cycle after the line is first sampled high again.
- R6: While `load_n` is held low, every rise of `busy_line` produces one load cycle, one cycle after the rise is sampled.
- R7: A load waits for the shared line, not for this device's own `busy_oe`. With `busy_oe` at 0 and the line held low from outside, no load occurs until the line goes high.
- R8: While `clr_n` is low, `cleared` is 1 and load strobes are ignored. After `clr_n` returns high, `cleared` stays 1 until the next load cycle, then reads 0.
- R9: A stored (pending) load is discarded if `clr_n` is low for at least one cycle before the line releases.
- R10: In a load cycle, `ld_en[i]` equals the written-since-load flag of channel i. A pulse on `hold_wr[i]` sets that flag. The flag is cleared at the end of the load cycle, except that a write arriving during the load cycle leaves it set.
- R11: Clearing does not alter the written-since-load flags.
- R12: After reset, `ld_en` is all zeros, `busy_oe` is 0, `cleared` is 0 and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| calc_busy | input | 1 | Holding-value calculation in progress |
| absel_wr | input | 1 | One-cycle pulse: A/B-select register written |
| hold_wr | input | NCH | Per-channel pulse: holding register written |
| busy_line | input | 1 | Sampled level of the shared open-drain busy line |
| busy_oe | output | 1 | 1 = pull the shared busy line low |
| ld_en | output | NCH | Per-channel output-register load enable |
| cleared | output | 1 | Outputs are in the cleared state |

## Verification
Some rules are checked by the in-line properties on every cycle:
- no load enable while the sampled line is low;
- no load in the cycle after clear was low;
- the cleared indicator rising one cycle after clear is low;
- the A/B hold timer starting and counting down;
- a flag dropping after its channel was loaded.

Other rules depend on an ordering of events, so only the directed scenarios can show them:
- replay of a stored strobe when the line releases;
- one update per line rise while the strobe is held;
- waiting on a line held low by another device;
- the cleared state persisting until the next load;
- discarding a pending load when clear intervenes;
- a write in the load cycle keeping its flag.

// File: rtl/dac_arb_pkg.sv
`timescale 1ns/1ps
package dac_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_FIRE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/absel_hold_timer.sv
`timescale 1ns/1ps
module absel_hold_timer #(
    parameter int HOLD_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

    // R2
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);

    // R2
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/chan_dirty_bank.sv
`timescale 1ns/1ps
module chan_dirty_bank #(
    parameter int NCH = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] wr,
    input  logic           fire,
    output logic [NCH-1:0] ld_en
);
    logic [NCH-1:0] flag_q;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (wr[i]) begin
                flag_q[i] <= 1'b1;
            end else if (ld_en[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
        assign ld_en[i] = fire & flag_q[i];
    end

    // R10
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en != '0) |=> ((flag_q & $past(ld_en) & ~$past(wr)) == '0));
endmodule

// File: rtl/load_seq_fsm.sv
`timescale 1ns/1ps
module load_seq_fsm
    import dac_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    input  logic clr_n,
    input  logic busy_line,
    output logic fire,
    output logic cleared
);
    arb_state_t state_q, state_d;
    logic load_q;
    logic line_q;
    logic load_fall;
    logic line_rise;
    logic req;

    assign load_fall = load_q & ~load_n;
    assign line_rise = busy_line & ~line_q;
    assign req       = clr_n & (load_fall | (~load_n & line_rise));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            load_q  <= 1'b1;
            line_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            load_q  <= load_n;
            line_q  <= busy_line;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = busy_line ? ST_FIRE : ST_PEND;
                end
            end
            ST_PEND: begin
                if (!clr_n) begin
                    state_d = ST_IDLE;
                end else if (busy_line) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (!clr_n) begin
                    state_d = ST_IDLE;
                end else if (!busy_line) begin
                    state_d = ST_PEND;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fire = (state_q == ST_FIRE) && busy_line && clr_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cleared <= 1'b0;
        end else if (!clr_n) begin
            cleared <= 1'b1;
        end else if (fire) begin
            cleared <= 1'b0;
        end
    end

    // R8
    clr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> cleared);

    // R9
    clr_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !fire);
endmodule

// File: rtl/dac_update_arbiter.sv
`timescale 1ns/1ps
module dac_update_arbiter #(
    parameter int NCH       = 40,
    parameter int ABSEL_CYC = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_n,
    input  logic           clr_n,
    input  logic           calc_busy,
    input  logic           absel_wr,
    input  logic [NCH-1:0] hold_wr,
    input  logic           busy_line,
    output logic           busy_oe,
    output logic [NCH-1:0] ld_en,
    output logic           cleared
);
    logic absel_act;
    logic fire;

    absel_hold_timer #(.HOLD_CYC(ABSEL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (absel_wr),
        .active (absel_act)
    );

    load_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .clr_n     (clr_n),
        .busy_line (busy_line),
        .fire      (fire),
        .cleared   (cleared)
    );

    chan_dirty_bank #(.NCH(NCH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (hold_wr),
        .fire  (fire),
        .ld_en (ld_en)
    );

    assign busy_oe = calc_busy | absel_act;

    // R3
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_line |-> (ld_en == '0));

    // R1
    own_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_busy |-> busy_oe);
endmodule

// File: tb/dac_update_arbiter_tb.sv
`timescale 1ns/1ps
module dac_update_arbiter_tb_top;
    localparam int NCH = 40;
    localparam int ABSEL = 30;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_n = 1'b1;
    logic           clr_n = 1'b1;
    logic           calc_busy = 1'b0;
    logic           absel_wr = 1'b0;
    logic [NCH-1:0] hold_wr = '0;
    logic           ext_hold = 1'b0;
    logic           busy_line;
    logic           busy_oe;
    logic [NCH-1:0] ld_en;
    logic           cleared;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign busy_line = ~(busy_oe | ext_hold);

    dac_update_arbiter #(.NCH(NCH), .ABSEL_CYC(ABSEL)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .clr_n     (clr_n),
        .calc_busy (calc_busy),
        .absel_wr  (absel_wr),
        .hold_wr   (hold_wr),
        .busy_line (busy_line),
        .busy_oe   (busy_oe),
        .ld_en     (ld_en),
        .cleared   (cleared)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ch(input int ch);
        hold_wr[ch] = 1'b1;
        @(negedge clk);
        hold_wr = '0;
    endtask

    task automatic t_reset();
        chk(ld_en == '0, "R12 ld_en", 64'(ld_en), 0);
        chk(busy_oe == 1'b0, "R12 busy_oe", 64'(busy_oe), 0);
        chk(cleared == 1'b0, "R12 cleared", 64'(cleared), 0);
        load_n = 1'b0;
        cyc(1);
        chk(ld_en == '0, "R12 no flags set", 64'(ld_en), 0);
        load_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_own_busy();
        calc_busy = 1'b1;
        #1;
        chk(busy_oe == 1'b1, "R1 calc busy drives line", 64'(busy_oe), 1);
        chk(busy_line == 1'b0, "R1 line low", 64'(busy_line), 0);
        @(negedge clk);
        calc_busy = 1'b0;
        #1;
        chk(busy_oe == 1'b0, "R1 released", 64'(busy_oe), 0);
        cyc(1);
    endtask

    task automatic t_absel();
        int cnt = 0;
        absel_wr = 1'b1;
        @(negedge clk);
        absel_wr = 1'b0;
        for (int i = 0; i < ABSEL + 10; i++) begin
            if (busy_oe) cnt++;
            @(negedge clk);
        end
        chk(cnt == ABSEL, "R2 hold length", 64'(cnt), 64'(ABSEL));
    endtask

    task automatic t_immediate();
        write_ch(1);
        write_ch(3);
        load_n = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(40'h0a), "R4 R10 immediate load", 64'(ld_en), 64'h0a);
        load_n = 1'b1;
        @(negedge clk);
        chk(ld_en == '0, "R4 single cycle", 64'(ld_en), 0);
        load_n = 1'b0;
        @(negedge clk);
        chk(ld_en == '0, "R10 flags cleared", 64'(ld_en), 0);
        load_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_pending();
        logic seen = 1'b0;
        write_ch(0);
        calc_busy = 1'b1;
        load_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ld_en != '0) seen = 1'b1;
        end
        chk(!seen, "R3 no load while busy", 64'(seen), 0);
        load_n = 1'b1;
        calc_busy = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(1), "R5 replay after release", 64'(ld_en), 1);
        cyc(2);
    endtask

    task automatic t_external();
        logic seen = 1'b0;
        ext_hold = 1'b1;
        write_ch(2);
        load_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ld_en != '0) seen = 1'b1;
        end
        chk(busy_oe == 1'b0, "R7 own line released", 64'(busy_oe), 0);
        chk(!seen, "R7 waits for shared line", 64'(seen), 0);
        load_n = 1'b1;
        ext_hold = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(4), "R7 fires on line high", 64'(ld_en), 4);
        cyc(2);
    endtask

    task automatic t_held();
        load_n = 1'b0;
        cyc(3);
        write_ch(5);
        calc_busy = 1'b1;
        cyc(2);
        calc_busy = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(32), "R6 first rise", 64'(ld_en), 32);
        write_ch(6);
        calc_busy = 1'b1;
        cyc(2);
        chk(ld_en == '0, "R6 idle while busy", 64'(ld_en), 0);
        calc_busy = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(64), "R6 second rise", 64'(ld_en), 64);
        load_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_clear();
        logic seen = 1'b0;
        write_ch(4);
        clr_n = 1'b0;
        @(negedge clk);
        chk(cleared == 1'b1, "R8 cleared set", 64'(cleared), 1);
        load_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (ld_en != '0) seen = 1'b1;
        end
        chk(!seen, "R8 load ignored in clear", 64'(seen), 0);
        load_n = 1'b1;
        @(negedge clk);
        clr_n = 1'b1;
        cyc(3);
        chk(cleared == 1'b1, "R8 stays cleared", 64'(cleared), 1);
        load_n = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(16), "R11 flag kept through clear", 64'(ld_en), 16);
        load_n = 1'b1;
        @(negedge clk);
        chk(cleared == 1'b0, "R8 cleared drops after load", 64'(cleared), 0);
        cyc(1);
    endtask

    task automatic t_discard();
        logic seen = 1'b0;
        write_ch(7);
        calc_busy = 1'b1;
        load_n = 1'b0;
        cyc(2);
        load_n = 1'b1;
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        calc_busy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ld_en != '0) seen = 1'b1;
        end
        chk(!seen, "R9 pending discarded", 64'(seen), 0);
        load_n = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(128), "R9 flag survives discard", 64'(ld_en), 128);
        load_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_wr_in_load();
        write_ch(0);
        load_n = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(1), "R10 load ch0", 64'(ld_en), 1);
        hold_wr[0] = 1'b1;
        @(negedge clk);
        hold_wr = '0;
        load_n = 1'b1;
        cyc(1);
        load_n = 1'b0;
        @(negedge clk);
        chk(ld_en == NCH'(1), "R10 write in load cycle kept", 64'(ld_en), 1);
        load_n = 1'b1;
        cyc(2);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_own_busy();
        t_absel();
        t_immediate();
        t_pending();
        t_external();
        t_held();
        t_clear();
        t_discard();
        t_wr_in_load();
        report();
    end

    initial begin
        #3000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule